// File: doc/BRIEF.md
# SPI NOR Page Program Splitter

This block accepts a write request made of a 24-bit flash start address, a byte count and a stream of data bytes. It turns the request into a sequence of page-program frames for a serial NOR flash. A byte-level serializer outside the block handles the clocking on the wire. The block hands it one byte at a time, with a flag that marks the final byte of each chip-select frame. For every frame the serializer returns one completion pulse, carrying the last byte it shifted in.

No program frame ever crosses a 256-byte page. The first chunk runs only to the next page boundary. Each later chunk is at most a full page, and each chunk carries an address recomputed as the start address plus the bytes already written. Before every chunk the block reads the status register until the busy bit is clear, then sets the write-enable latch.

A request that would run past the end of the device produces no traffic and is answered with an error. A zero-length request is answered at once with a count of zero. The reported count includes only payload bytes.

The controller states are:
- `ST_IDLE`: waits for a request.
- `ST_POLL_OP`: sends the status-read opcode.
- `ST_POLL_DUMMY`: sends the dummy byte that clocks in the status.
- `ST_POLL_END`: waits for the status frame to complete. It goes back to `ST_POLL_OP` while the device is busy, otherwise on to `ST_WREN`.
- `ST_WREN`: sends write-enable.
- `ST_WREN_END`: waits for completion, then goes to `ST_HDR`.
- `ST_HDR`: sends the opcode and the three address bytes, then goes to `ST_DATA`.
- `ST_DATA`: passes the payload through until the chunk is exhausted.
- `ST_PROG_END`: waits for completion. It goes to `ST_POLL_OP` if bytes remain, otherwise to `ST_FINISH`.
- `ST_FINISH`: one-cycle completion report, then back to `ST_IDLE`.

From `ST_IDLE`, a zero-length or out-of-range request goes directly to `ST_FINISH`, and any other request goes to `ST_POLL_OP`.

Top module: `ppsplit_top`

## Requirements
- R1: After reset the block is idle: `req_ready`=1, `byte_valid`=0, `din_ready`=0, `done`=0.
- R2: The first chunk holds min(len, 256 − (addr mod 256)) bytes. Every later chunk holds min(256, bytes remaining). A chunk therefore never crosses a 256-byte page.
- R3: A program frame is the byte 0x02, then the chunk address (start + bytes already written) as three bytes, most significant first, then the chunk's payload. `byte_last`=1 only on the chunk's final payload byte. A byte offered and not taken stays unchanged.
- R4: Before every chunk the block sends a status frame of 0x05 followed by a dummy 0x00 with `byte_last`=1. It repeats the status frame for as long as bit 0 of the returned `rx_data` is 1.
- R5: After the status poll reports idle, the block sends a single-byte write-enable frame, 0x06 with `byte_last`=1, before the program frame.
- R6: A request with addr + len > DEV_BYTES produces no serializer bytes and takes no data. It completes with `done_err`=1 and `done_count`=0.
- R7: `done_count` equals the number of payload bytes written. Opcode, address and status bytes are not counted.
- R8: `din_ready` is 0 except while payload bytes of a program frame are being passed. Each taken input byte appears unchanged on `byte_data`, and exactly len bytes are taken.
- R9: A zero-length request produces no serializer bytes. It completes with `done_err`=0 and `done_count`=0.
- R10: After the final byte of any frame is taken, no further byte is offered until `rx_valid` reports that frame complete.
- R11: `done` is a one-cycle pulse, and `req_ready` is 1 only in the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block idle, request taken |
| req_addr | input | 24 | Flash start address |
| req_len | input | LEN_W | Payload byte count |
| din_valid | input | 1 | Payload byte present |
| din_ready | output | 1 | Payload byte taken |
| din_data | input | 8 | Payload byte |
| byte_valid | output | 1 | Byte offered to the serializer |
| byte_ready | input | 1 | Serializer takes the byte |
| byte_data | output | 8 | Byte to shift out |
| byte_last | output | 1 | Final byte of the chip-select frame |
| rx_valid | input | 1 | Frame completed by the serializer |
| rx_data | input | 8 | Last byte shifted in during that frame |
| done | output | 1 | Request finished (pulse) |
| done_err | output | 1 | Request rejected as out of range |
| done_count | output | LEN_W | Payload bytes written |

## Verification
The assertions assume two things about the neighbours. The serializer returns exactly one `rx_valid` pulse per frame, and only after that frame's final byte. The data source holds `din_valid` and `din_data` steady until `din_ready` takes the byte. The bench models both neighbours under these rules. The serializer model answers each frame after a fixed delay and reports busy for a chosen number of polls. The source inserts idle gaps only between bytes, never while a byte is waiting. Both models insert back-pressure and gaps without breaking either rule.

// File: rtl/ppsplit_pkg.sv
package ppsplit_pkg;

    localparam int FLASH_ADDR_W = 24;
    localparam int WIP_BIT      = 0;

    localparam logic [7:0] OP_PROG  = 8'h02;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] DUMMY_TX = 8'h00;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_POLL_OP,
        ST_POLL_DUMMY,
        ST_POLL_END,
        ST_WREN,
        ST_WREN_END,
        ST_HDR,
        ST_DATA,
        ST_PROG_END,
        ST_FINISH
    } ppsplit_state_e;

endpackage

// File: rtl/ppsplit_range.sv
// Decides whether a request would run past the end of the device.
module ppsplit_range #(
    parameter int ADDR_W    = 24,
    parameter int LEN_W     = 16,
    parameter int DEV_BYTES = 1 << 20
) (
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              too_far
);
    localparam int SUM_W = ((ADDR_W > LEN_W) ? ADDR_W : LEN_W) + 1;

    logic [SUM_W-1:0] end_addr;

    always_comb begin
        end_addr = SUM_W'(start_addr) + SUM_W'(req_len);
        too_far  = (end_addr > SUM_W'(DEV_BYTES));
    end
endmodule

// File: rtl/ppsplit_chunk.sv
// Size of the next program chunk: limited by the page room and the bytes left.
module ppsplit_chunk #(
    parameter int ADDR_W     = 24,
    parameter int LEN_W      = 16,
    parameter int PAGE_BYTES = 256
) (
    input  logic [ADDR_W-1:0]               cur_addr,
    input  logic [LEN_W-1:0]                remain,
    output logic [$clog2(PAGE_BYTES):0]     chunk_len
);
    localparam int PG_W = $clog2(PAGE_BYTES);

    logic [PG_W-1:0] offset;
    logic [PG_W:0]   room;

    always_comb begin
        offset = cur_addr[PG_W-1:0];
        room   = (PG_W+1)'(PAGE_BYTES) - {1'b0, offset};
        if (remain < LEN_W'(room)) begin
            chunk_len = remain[PG_W:0];
        end else begin
            chunk_len = room;
        end
    end
endmodule

// File: rtl/ppsplit_track.sv
// Address, remaining, chunk and header counters of the splitter.
module ppsplit_track #(
    parameter int ADDR_W     = 24,
    parameter int LEN_W      = 16,
    parameter int PAGE_BYTES = 256
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load,
    input  logic [ADDR_W-1:0]           load_addr,
    input  logic [LEN_W-1:0]            load_len,
    input  logic                        chunk_load,
    input  logic [$clog2(PAGE_BYTES):0] chunk_len,
    input  logic                        hdr_adv,
    input  logic                        data_take,
    output logic [ADDR_W-1:0]           cur_addr,
    output logic [LEN_W-1:0]            remain,
    output logic [$clog2(PAGE_BYTES):0] chunk_left,
    output logic [1:0]                  hdr_idx,
    output logic [LEN_W-1:0]            written
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr   <= '0;
            remain     <= '0;
            chunk_left <= '0;
            hdr_idx    <= '0;
            written    <= '0;
        end else begin
            if (load) begin
                cur_addr <= load_addr;
                remain   <= load_len;
                written  <= '0;
            end else if (data_take) begin
                cur_addr <= cur_addr + ADDR_W'(1);
                remain   <= remain - LEN_W'(1);
                written  <= written + LEN_W'(1);
            end

            if (chunk_load) begin
                chunk_left <= chunk_len;
                hdr_idx    <= '0;
            end else begin
                if (data_take) begin
                    chunk_left <= chunk_left - 1'b1;
                end
                if (hdr_adv) begin
                    hdr_idx <= hdr_idx + 2'd1;
                end
            end
        end
    end
endmodule

// File: rtl/ppsplit_top.sv
module ppsplit_top
    import ppsplit_pkg::*;
#(
    parameter int LEN_W      = 16,
    parameter int PAGE_BYTES = 256,
    parameter int DEV_BYTES  = 1 << 20
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [FLASH_ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]        req_len,
    input  logic                    din_valid,
    output logic                    din_ready,
    input  logic [7:0]              din_data,
    output logic                    byte_valid,
    input  logic                    byte_ready,
    output logic [7:0]              byte_data,
    output logic                    byte_last,
    input  logic                    rx_valid,
    input  logic [7:0]              rx_data,
    output logic                    done,
    output logic                    done_err,
    output logic [LEN_W-1:0]        done_count
);
    localparam int PG_W = $clog2(PAGE_BYTES);

    ppsplit_state_e state, state_nx;

    logic                    err_q;
    logic                    too_far;
    logic [PG_W:0]           chunk_len;
    logic [FLASH_ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]        remain;
    logic [PG_W:0]           chunk_left;
    logic [1:0]              hdr_idx;
    logic [LEN_W-1:0]        written;

    logic accept;
    logic chunk_load;
    logic hdr_adv;
    logic data_take;

    ppsplit_range #(
        .ADDR_W    (FLASH_ADDR_W),
        .LEN_W     (LEN_W),
        .DEV_BYTES (DEV_BYTES)
    ) u_range (
        .start_addr (req_addr),
        .req_len    (req_len),
        .too_far    (too_far)
    );

    ppsplit_chunk #(
        .ADDR_W     (FLASH_ADDR_W),
        .LEN_W      (LEN_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_chunk (
        .cur_addr  (cur_addr),
        .remain    (remain),
        .chunk_len (chunk_len)
    );

    ppsplit_track #(
        .ADDR_W     (FLASH_ADDR_W),
        .LEN_W      (LEN_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .load_addr  (req_addr),
        .load_len   (req_len),
        .chunk_load (chunk_load),
        .chunk_len  (chunk_len),
        .hdr_adv    (hdr_adv),
        .data_take  (data_take),
        .cur_addr   (cur_addr),
        .remain     (remain),
        .chunk_left (chunk_left),
        .hdr_idx    (hdr_idx),
        .written    (written)
    );

    // State register and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            err_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (accept) begin
                err_q <= (req_len != '0) && too_far;
            end
        end
    end

    // Next-state logic.
    always_comb begin
        state_nx   = state;
        accept     = 1'b0;
        chunk_load = 1'b0;
        hdr_adv    = 1'b0;
        data_take  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    if (req_len == '0 || too_far) begin
                        state_nx = ST_FINISH;
                    end else begin
                        state_nx = ST_POLL_OP;
                    end
                end
            end
            ST_POLL_OP: begin
                if (byte_ready) state_nx = ST_POLL_DUMMY;
            end
            ST_POLL_DUMMY: begin
                if (byte_ready) state_nx = ST_POLL_END;
            end
            ST_POLL_END: begin
                if (rx_valid) begin
                    state_nx = rx_data[WIP_BIT] ? ST_POLL_OP : ST_WREN;
                end
            end
            ST_WREN: begin
                if (byte_ready) state_nx = ST_WREN_END;
            end
            ST_WREN_END: begin
                if (rx_valid) begin
                    chunk_load = 1'b1;
                    state_nx   = ST_HDR;
                end
            end
            ST_HDR: begin
                if (byte_ready) begin
                    hdr_adv = 1'b1;
                    if (hdr_idx == 2'd3) state_nx = ST_DATA;
                end
            end
            ST_DATA: begin
                if (din_valid && byte_ready) begin
                    data_take = 1'b1;
                    if (chunk_left == (PG_W+1)'(1)) state_nx = ST_PROG_END;
                end
            end
            ST_PROG_END: begin
                if (rx_valid) begin
                    state_nx = (remain == '0) ? ST_FINISH : ST_POLL_OP;
                end
            end
            ST_FINISH: begin
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Output logic.
    always_comb begin
        req_ready  = 1'b0;
        din_ready  = 1'b0;
        byte_valid = 1'b0;
        byte_data  = 8'h00;
        byte_last  = 1'b0;
        done       = 1'b0;
        done_err   = err_q;
        done_count = written;
        unique case (state)
            ST_IDLE: req_ready = 1'b1;
            ST_POLL_OP: begin
                byte_valid = 1'b1;
                byte_data  = OP_RDSR;
            end
            ST_POLL_DUMMY: begin
                byte_valid = 1'b1;
                byte_data  = DUMMY_TX;
                byte_last  = 1'b1;
            end
            ST_WREN: begin
                byte_valid = 1'b1;
                byte_data  = OP_WREN;
                byte_last  = 1'b1;
            end
            ST_HDR: begin
                byte_valid = 1'b1;
                unique case (hdr_idx)
                    2'd0: byte_data = OP_PROG;
                    2'd1: byte_data = cur_addr[23:16];
                    2'd2: byte_data = cur_addr[15:8];
                    2'd3: byte_data = cur_addr[7:0];
                    default: byte_data = OP_PROG;
                endcase
            end
            ST_DATA: begin
                byte_valid = din_valid;
                byte_data  = din_data;
                byte_last  = (chunk_left == (PG_W+1)'(1));
                din_ready  = byte_ready;
            end
            ST_FINISH: done = 1'b1;
            ST_POLL_END, ST_WREN_END, ST_PROG_END: begin
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/ppsplit_chk.sv
module ppsplit_chk #(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             din_valid,
    input logic             din_ready,
    input logic [7:0]       din_data,
    input logic             byte_valid,
    input logic             byte_ready,
    input logic [7:0]       byte_data,
    input logic             byte_last,
    input logic             done,
    input logic             done_err,
    input logic [LEN_W-1:0] done_count
);
    // R1, R11: idle state offers nothing downstream and takes no data.
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!byte_valid && !din_ready));

    // R8: a taken payload byte is the byte offered downstream.
    a_r8_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (din_valid && din_ready) |-> (byte_valid && byte_data == din_data));

    // R3: an offered byte waits unchanged until taken.
    a_r3_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !byte_ready) |=>
            (byte_valid && $stable(byte_data) && $stable(byte_last)));

    // R10: nothing offered right after a frame's final byte.
    a_r10_frame_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && byte_ready && byte_last) |=> !byte_valid);

    // R11: completion is a single-cycle pulse followed by idle.
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    // R6: a rejected request reports zero bytes.
    a_r6_reject_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_err) |-> (done_count == '0));
endmodule

bind ppsplit_top ppsplit_chk #(.LEN_W(LEN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .din_valid  (din_valid),
    .din_ready  (din_ready),
    .din_data   (din_data),
    .byte_valid (byte_valid),
    .byte_ready (byte_ready),
    .byte_data  (byte_data),
    .byte_last  (byte_last),
    .done       (done),
    .done_err   (done_err),
    .done_count (done_count)
);

// File: tb/sim_ppsplit_top.sv
`timescale 1ns/1ps
module sim_ppsplit_top;
    localparam int LEN_W = 16;
    localparam int DEV   = 1 << 20;
    localparam int CAP_N = 2048;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [23:0]      req_addr = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic             din_valid;
    logic             din_ready;
    logic [7:0]       din_data;
    logic             byte_valid;
    logic             byte_ready;
    logic [7:0]       byte_data;
    logic             byte_last;
    logic             rx_valid;
    logic [7:0]       rx_data;
    logic             done;
    logic             done_err;
    logic [LEN_W-1:0] done_count;

    int n_chk = 0;
    int n_bad = 0;

    // Bench configuration, driven from the test tasks.
    logic clr      = 1'b0;
    int   busy_cfg = 0;
    logic gaps     = 1'b0;

    // Model state.
    logic [8:0] cap [0:CAP_N-1];
    int         cap_n;
    int         src_i;
    int         busy_left;
    int         rx_dly;
    logic [7:0] rx_stat;
    logic       in_frame;
    logic [7:0] fr_op;
    int         gap_viol;
    int         cyc;

    logic [8:0] exp_b [0:CAP_N-1];
    int         exp_n;

    always #10 clk = ~clk;

    ppsplit_top #(.LEN_W(LEN_W), .PAGE_BYTES(256), .DEV_BYTES(DEV)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len),
        .din_valid(din_valid), .din_ready(din_ready), .din_data(din_data),
        .byte_valid(byte_valid), .byte_ready(byte_ready),
        .byte_data(byte_data), .byte_last(byte_last),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .done(done), .done_err(done_err), .done_count(done_count)
    );

    function automatic logic [7:0] pat(input int k);
        return 8'((k * 37 + 11) ^ (k >> 8));
    endfunction

    assign din_data = pat(src_i);

    // Serializer model: takes bytes, records them, answers each frame.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n || clr) begin
            cap_n      <= 0;
            busy_left  <= busy_cfg;
            rx_dly     <= 0;
            rx_valid   <= 1'b0;
            rx_stat    <= 8'h00;
            in_frame   <= 1'b0;
            fr_op      <= 8'h00;
            gap_viol   <= 0;
            byte_ready <= 1'b1;
        end else begin
            byte_ready <= gaps ? ((cyc % 3) != 0) : 1'b1;
            rx_valid   <= 1'b0;
            if (rx_dly != 0) begin
                rx_dly <= rx_dly - 1;
                if (rx_dly == 1) rx_valid <= 1'b1;
            end
            if (byte_valid && byte_ready) begin
                if (cap_n < CAP_N) cap[cap_n] <= {byte_last, byte_data};
                cap_n <= cap_n + 1;
                if (rx_dly != 0) gap_viol <= gap_viol + 1;
                if (!in_frame) fr_op <= byte_data;
                if (byte_last) begin
                    in_frame <= 1'b0;
                    rx_dly   <= 3;
                    if ((in_frame ? fr_op : byte_data) == 8'h05 && busy_left > 0) begin
                        rx_stat   <= 8'hA1;
                        busy_left <= busy_left - 1;
                    end else begin
                        rx_stat <= 8'hA0;
                    end
                end else begin
                    in_frame <= 1'b1;
                end
            end
        end
    end
    assign rx_data = rx_stat;

    // Data source model: holds each byte until taken.
    always @(posedge clk) begin
        if (!rst_n || clr) begin
            src_i     <= 0;
            din_valid <= 1'b0;
        end else if (din_valid && din_ready) begin
            src_i     <= src_i + 1;
            din_valid <= gaps ? ((cyc % 4) != 1) : 1'b1;
        end else if (!din_valid) begin
            din_valid <= gaps ? ((cyc % 4) != 1) : 1'b1;
        end
    end

    task automatic check(input string req, input logic ok, input string what,
                         input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic push(input logic lst, input logic [7:0] b);
        exp_b[exp_n] = {lst, b};
        exp_n++;
    endtask

    // Expected byte stream built from R2-R5.
    task automatic build(input int addr, input int len, input int busy);
        int wr = 0;
        int k = 0;
        int polls = busy + 1;
        exp_n = 0;
        while (wr < len) begin
            int a = addr + wr;
            int room = 256 - (a % 256);
            int ch = (len - wr < room) ? len - wr : room;
            for (int p = 0; p < polls; p++) begin
                push(1'b0, 8'h05);
                push(1'b1, 8'h00);
            end
            polls = 1;
            push(1'b1, 8'h06);
            push(1'b0, 8'h02);
            push(1'b0, 8'(a >> 16));
            push(1'b0, 8'(a >> 8));
            push(1'b0, 8'(a));
            for (int j = 0; j < ch; j++) begin
                push(j == ch - 1, pat(k));
                k++;
            end
            wr += ch;
        end
    endtask

    task automatic start(input int busy, input logic g);
        @(negedge clk);
        busy_cfg = busy;
        gaps = g;
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    // Issues one request and checks everything it produced.
    task automatic run_req(input string tag, input int addr, input int len,
                           input int busy, input logic g, input logic exp_err);
        int t = 0;
        int bad_at = -1;
        logic got_err;
        int got_cnt;
        start(busy, g);
        if (exp_err || len == 0) exp_n = 0;
        else build(addr, len, busy);
        req_addr  = 24'(addr);
        req_len   = LEN_W'(len);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done && t < 50000) begin
            @(negedge clk);
            t++;
        end
        check("R11", t < 50000, {tag, " completion"}, t, 0);
        got_err = done_err;
        got_cnt = int'(done_count);
        @(negedge clk);
        check("R11", !done && req_ready, {tag, " done pulse"}, int'(done), 0);
        check(exp_err ? "R6" : "R7", got_err == exp_err, {tag, " error flag"},
              int'(got_err), int'(exp_err));
        check(len == 0 ? "R9" : "R7", got_cnt == (exp_err ? 0 : len),
              {tag, " reported count"}, got_cnt, exp_err ? 0 : len);
        check("R4", cap_n == exp_n, {tag, " serializer byte count"}, cap_n, exp_n);
        for (int i = 0; i < exp_n && i < cap_n; i++) begin
            if (bad_at < 0 && cap[i] !== exp_b[i]) bad_at = i;
        end
        check("R3", bad_at < 0, {tag, " stream byte (index below)"},
              bad_at < 0 ? 0 : int'(cap[bad_at]),
              bad_at < 0 ? 0 : int'(exp_b[bad_at]));
        check("R8", src_i == (exp_err ? 0 : len), {tag, " bytes taken"},
              src_i, exp_err ? 0 : len);
        check("R10", gap_viol == 0, {tag, " bytes before frame completion"},
              gap_viol, 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1", req_ready == 1'b1, "req_ready after reset", int'(req_ready), 1);
        check("R1", byte_valid == 1'b0, "byte_valid after reset", int'(byte_valid), 0);
        check("R1", din_ready == 1'b0, "din_ready after reset", int'(din_ready), 0);
        check("R1", done == 1'b0, "done after reset", int'(done), 0);
    endtask

    // R2: single chunk inside one page.
    task automatic t_small;
        run_req("in-page", 24'h000010, 20, 0, 1'b0, 1'b0);
    endtask

    // R4: full aligned page with busy polls and back-pressure.
    task automatic t_full_page;
        run_req("aligned page", 24'h000100, 256, 2, 1'b1, 1'b0);
    endtask

    // R2, R3: crossing two boundaries, three chunks.
    task automatic t_cross;
        run_req("cross", 24'h0000F0, 300, 1, 1'b1, 1'b0);
    endtask

    // R2: offset plus length exactly one page.
    task automatic t_exact_end;
        run_req("page end", 24'h0001C0, 64, 0, 1'b0, 1'b0);
    endtask

    // R9: zero-length request.
    task automatic t_zero;
        run_req("zero length", 24'h000200, 0, 0, 1'b0, 1'b0);
    endtask

    // R6: one byte past the device end rejected, exact end accepted.
    task automatic t_range;
        run_req("past end", DEV - 10, 11, 0, 1'b0, 1'b1);
        run_req("device end", DEV - 10, 10, 0, 1'b1, 1'b0);
    endtask

    // R5: long multi-page write from an odd address.
    task automatic t_long;
        run_req("long", 24'h012345, 700, 3, 1'b1, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_small();
        t_full_page();
        t_cross();
        t_exact_end();
        t_zero();
        t_range();
        t_long();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule